// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs a whole register-addressed I2C transfer on its own. A request gives the chip address, how many register-address bytes to send (zero to four), a byte count and an operation: write, read or probe. The sequencer then drives a byte-level bus master with one command at a time. After each command it polls the master's completion flag and compares the status code that comes back with the code that step should produce. Write data is pulled from a stream input one byte per command. Read data is pushed out one byte per accepted receive.

The first step that fails ends the transfer early. A failure is either a wrong status code or a flag that never rises within the poll budget. The failure is packed into a 32-bit word: error class, the control byte in force, the status seen and the status expected. A stop command is issued at the end of every transfer, including failed ones, and the sequencer waits for the bus-idle status before it finishes. A one-cycle done pulse closes each request. Its error word is zero when the transfer succeeded.

Top module: `i2c_txn_seq`

## Requirements
- R1: A write issues start (expects 0x08), then the chip address shifted left with bit 0 clear (expects 0x18), then the register-address bytes, then the data bytes, each expecting 0x28, then a stop. Data bytes are taken from `wr_data` in the cycle `wr_pop` is high.
- R2: A read with one or more register-address bytes sends them as in a write. It then issues a repeated start (expects 0x10) and the chip address with bit 0 set (expects 0x40). A read with no register-address bytes issues a plain start (expects 0x08) followed directly by the read address.
- R3: Register-address bytes go out most significant first: byte index alen-1 of `req_addr` first, index 0 last.
- R4: Every received byte except the last is acknowledged (control 0x44, expects 0x50). The last is not acknowledged (control 0x40, expects 0x58). Each accepted byte appears on `rd_data` with a one-cycle `rd_valid`, in order.
- R5: A probe sends start, then the read address, then receives exactly one byte without acknowledge, then stops. The request's address-byte count and length are ignored.
- R6: A status that differs from the expected code ends the transfer with error word {0x01, control, status, expected} in bits 31:24, 23:16, 15:8 and 7:0. The control field is the issued control byte with bit 3 showing the completion flag.
- R7: The flag is sampled once every TICK_CYCLES cycles, POLL_LIMIT+1 times at most. The first sample falls in the cycle after the command. If the flag never rises, the error word is {0x02, control, status, expected}, and the stop command follows POLL_LIMIT*TICK_CYCLES+2 cycles after the failed command.
- R8: Every transfer ends with a stop command (control 0x50). Completion of the stop means status 0xF8. If that status never appears, class 0x02 is reported with expected 0xF8, but only when no earlier error occurred; otherwise the first error is kept.
- R9: `busy` rises in the cycle after an accepted `req_valid` and stays high until `done`, a single-cycle pulse during which `busy` is low. `err_word` holds zero after a success. A `req_valid` while busy is ignored.
- R10: The control byte uses bit 6 enable (always set), bit 5 start, bit 4 stop and bit 2 acknowledge. Bit 3 is never driven on a command. `cmd_data` is zero for start, repeated start, receive and stop commands.
- R11: After reset `busy`, `done` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 write, 1 read, 2 probe |
| req_chip | input | 7 | 7-bit chip address |
| req_alen | input | AIW | Register-address byte count, 0 to ADDR_BYTES |
| req_addr | input | 8*ADDR_BYTES | Register address, byte 0 least significant |
| req_len | input | LEN_W | Data byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_word | output | 32 | Packed error word, zero on success |
| wr_data | input | 8 | Next write byte |
| wr_pop | output | 1 | Write byte consumed this cycle |
| rd_valid | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Command strobe to the byte master |
| cmd_ctrl | output | 8 | Command control byte |
| cmd_data | output | 8 | Byte to transmit with the command |
| bus_flag | input | 1 | Byte master completion flag |
| bus_status | input | 8 | Byte master status code |
| bus_rx | input | 8 | Byte master received byte |

## Verification
The main function is driven with writes, reads and probes. Address-byte counts of zero, one, two and four separate the plain-start read path from the repeated-start path and expose byte order. Lengths of zero, one and several separate the acknowledge pattern of the last received byte from the others. Faults are injected by the responding bus model: a wrong status on the address, data and receive steps, a flag that never rises, a stop that never reaches idle, and a stop failure combined with an earlier error. These check the error packing, the poll window length and the first-error priority. One transfer is also hit with a second request while busy, to show the request is ignored.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_STOP_ISSUE,
        ST_STOP_WAIT
    } seq_state_e;

    typedef enum logic [2:0] {
        SP_START,
        SP_RSTART,
        SP_ADDR_W,
        SP_REG,
        SP_DATA_W,
        SP_ADDR_R,
        SP_RECV
    } seq_step_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_PROBE = 2'd2
    } seq_op_e;

    localparam logic [7:0] CTL_EN  = 8'h40;
    localparam logic [7:0] CTL_STA = 8'h20;
    localparam logic [7:0] CTL_STO = 8'h10;
    localparam logic [7:0] CTL_FLG = 8'h08;
    localparam logic [7:0] CTL_ACK = 8'h04;

    localparam logic [7:0] CODE_START   = 8'h08;
    localparam logic [7:0] CODE_RSTART  = 8'h10;
    localparam logic [7:0] CODE_AW_ACK  = 8'h18;
    localparam logic [7:0] CODE_DW_ACK  = 8'h28;
    localparam logic [7:0] CODE_AR_ACK  = 8'h40;
    localparam logic [7:0] CODE_DR_ACK  = 8'h50;
    localparam logic [7:0] CODE_DR_NAK  = 8'h58;
    localparam logic [7:0] CODE_IDLE    = 8'hF8;

    localparam logic [7:0] ERR_STATUS  = 8'h01;
    localparam logic [7:0] ERR_TIMEOUT = 8'h02;

endpackage

// File: rtl/i2c_seq_step.sv
// Decodes the current step into control byte, transmit byte and expected status.
module i2c_seq_step
    import i2c_seq_pkg::*;
(
    input  seq_step_e  step,
    input  logic       last_byte,
    input  logic [6:0] chip,
    input  logic [7:0] reg_byte,
    input  logic [7:0] wr_byte,
    output logic [7:0] ctrl,
    output logic [7:0] data,
    output logic [7:0] expect_code
);
    always_comb begin
        ctrl        = CTL_EN;
        data        = 8'h00;
        expect_code = CODE_IDLE;
        case (step)
            SP_START: begin
                ctrl        = CTL_EN | CTL_STA;
                expect_code = CODE_START;
            end
            SP_RSTART: begin
                ctrl        = CTL_EN | CTL_STA;
                expect_code = CODE_RSTART;
            end
            SP_ADDR_W: begin
                data        = {chip, 1'b0};
                expect_code = CODE_AW_ACK;
            end
            SP_REG: begin
                data        = reg_byte;
                expect_code = CODE_DW_ACK;
            end
            SP_DATA_W: begin
                data        = wr_byte;
                expect_code = CODE_DW_ACK;
            end
            SP_ADDR_R: begin
                data        = {chip, 1'b1};
                expect_code = CODE_AR_ACK;
            end
            SP_RECV: begin
                ctrl        = last_byte ? CTL_EN : (CTL_EN | CTL_ACK);
                expect_code = last_byte ? CODE_DR_NAK : CODE_DR_ACK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_seq_poll.sv
// Samples a condition once per tick window, up to POLL_LIMIT+1 samples.
module i2c_seq_poll #(
    parameter int POLL_LIMIT  = 1000,
    parameter int TICK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    input  logic cond,
    output logic hit,
    output logic expire
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int TW = $clog2(TICK_CYCLES + 1);
    localparam logic [PW-1:0] PMAX   = PW'(POLL_LIMIT);
    localparam logic [TW-1:0] TRELOAD = TW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic [PW-1:0] polls;
    } poll_t;

    poll_t q, d;
    logic  sample;

    assign sample = run && (q.tick == '0);
    assign hit    = sample && cond;
    assign expire = sample && !cond && (q.polls == PMAX);

    always_comb begin
        d = q;
        if (arm) begin
            d.tick  = '0;
            d.polls = '0;
        end else if (run) begin
            if (q.tick == '0) begin
                if (!cond && (q.polls != PMAX)) begin
                    d.polls = q.polls + 1'b1;
                    d.tick  = TRELOAD;
                end
            end else begin
                d.tick = q.tick - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int ADDR_BYTES  = 4,
    parameter int POLL_LIMIT  = 1000,
    parameter int TICK_CYCLES = 4,
    localparam int AW  = 8 * ADDR_BYTES,
    localparam int AIW = $clog2(ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [6:0]       req_chip,
    input  logic [AIW-1:0]   req_alen,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             done,
    output logic [31:0]      err_word,
    input  logic [7:0]       wr_data,
    output logic             wr_pop,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             cmd_valid,
    output logic [7:0]       cmd_ctrl,
    output logic [7:0]       cmd_data,
    input  logic             bus_flag,
    input  logic [7:0]       bus_status,
    input  logic [7:0]       bus_rx
);
    localparam logic [7:0] STOP_CTL = CTL_EN | CTL_STO;

    typedef struct packed {
        seq_state_e       st;
        seq_step_e        step;
        seq_op_e          op;
        logic [6:0]       chip;
        logic [AIW-1:0]   alen;
        logic [AIW-1:0]   ridx;
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] cnt;
        logic [31:0]      err;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic [7:0] s_ctrl, s_data, s_expect, reg_byte, ctrl_rep;
    logic       poll_arm, poll_run, poll_cond, hit, expire, status_ok;

    assign reg_byte = q.addr[{q.ridx, 3'b000} +: 8];

    i2c_seq_step u_step (
        .step        (q.step),
        .last_byte   (q.cnt == LEN_W'(1)),
        .chip        (q.chip),
        .reg_byte    (reg_byte),
        .wr_byte     (wr_data),
        .ctrl        (s_ctrl),
        .data        (s_data),
        .expect_code (s_expect)
    );

    i2c_seq_poll #(
        .POLL_LIMIT  (POLL_LIMIT),
        .TICK_CYCLES (TICK_CYCLES)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (poll_arm),
        .run    (poll_run),
        .cond   (poll_cond),
        .hit    (hit),
        .expire (expire)
    );

    // Command and stream outputs
    assign cmd_valid = (q.st == ST_ISSUE) || (q.st == ST_STOP_ISSUE);
    assign cmd_ctrl  = (q.st == ST_ISSUE) ? s_ctrl : STOP_CTL;
    assign cmd_data  = (q.st == ST_ISSUE) ? s_data : 8'h00;
    assign wr_pop    = (q.st == ST_ISSUE) && (q.step == SP_DATA_W);

    assign poll_arm  = cmd_valid;
    assign poll_run  = (q.st == ST_WAIT) || (q.st == ST_STOP_WAIT);
    assign poll_cond = (q.st == ST_WAIT) ? bus_flag : (bus_status == CODE_IDLE);
    assign status_ok = (bus_status == s_expect);
    assign ctrl_rep  = ((q.st == ST_WAIT) ? s_ctrl : STOP_CTL) | (bus_flag ? CTL_FLG : 8'h00);

    assign rd_valid  = (q.st == ST_WAIT) && hit && status_ok && (q.step == SP_RECV);
    assign rd_data   = bus_rx;

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign err_word  = q.err;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_ISSUE;
                    d.step = SP_START;
                    d.chip = req_chip;
                    d.addr = req_addr;
                    d.err  = '0;
                    d.ridx = '0;
                    if (req_op == 2'd2) begin
                        d.op   = OP_PROBE;
                        d.alen = '0;
                        d.cnt  = LEN_W'(1);
                    end else begin
                        d.op   = (req_op == 2'd1) ? OP_READ : OP_WRITE;
                        d.alen = req_alen;
                        d.cnt  = req_len;
                    end
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (hit && status_ok) begin
                    d.st = ST_ISSUE;
                    case (q.step)
                        SP_START:
                            d.step = ((q.op != OP_WRITE) && (q.alen == '0)) ? SP_ADDR_R : SP_ADDR_W;
                        SP_RSTART:
                            d.step = SP_ADDR_R;
                        SP_ADDR_W: begin
                            if (q.alen != '0) begin
                                d.step = SP_REG;
                                d.ridx = q.alen - 1'b1;
                            end else if (q.cnt != '0) begin
                                d.step = SP_DATA_W;
                            end else begin
                                d.st = ST_STOP_ISSUE;
                            end
                        end
                        SP_REG: begin
                            if (q.ridx != '0)           d.ridx = q.ridx - 1'b1;
                            else if (q.op != OP_WRITE)  d.step = SP_RSTART;
                            else if (q.cnt != '0)       d.step = SP_DATA_W;
                            else                        d.st   = ST_STOP_ISSUE;
                        end
                        SP_ADDR_R: begin
                            if (q.cnt != '0) d.step = SP_RECV;
                            else             d.st   = ST_STOP_ISSUE;
                        end
                        default: begin
                            d.cnt = q.cnt - 1'b1;
                            if (q.cnt == LEN_W'(1)) d.st = ST_STOP_ISSUE;
                        end
                    endcase
                end else if (hit) begin
                    d.err = {ERR_STATUS, ctrl_rep, bus_status, s_expect};
                    d.st  = ST_STOP_ISSUE;
                end else if (expire) begin
                    d.err = {ERR_TIMEOUT, ctrl_rep, bus_status, s_expect};
                    d.st  = ST_STOP_ISSUE;
                end
            end
            ST_STOP_ISSUE: d.st = ST_STOP_WAIT;
            ST_STOP_WAIT: begin
                if (hit || expire) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (expire && (q.err == '0))
                        d.err = {ERR_TIMEOUT, ctrl_rep, bus_status, CODE_IDLE};
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.step <= SP_START;
            q.op   <= OP_WRITE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic [7:0] err_class,
    input logic       cmd_valid,
    input logic [7:0] cmd_ctrl,
    input logic       wr_pop,
    input logic       rd_valid
);
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r9_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    a_r7_one_cmd_per_poll: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r10_ctrl_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_ctrl[6] && !cmd_ctrl[3] && busy));

    a_r6_err_class: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_class <= 8'h02));

    a_r1_pop_on_data_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> (cmd_valid && cmd_ctrl == 8'h40));

    a_r4_rd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && !cmd_valid));
endmodule

bind i2c_txn_seq i2c_txn_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err_class (err_word[31:24]),
    .cmd_valid (cmd_valid),
    .cmd_ctrl  (cmd_ctrl),
    .wr_pop    (wr_pop),
    .rd_valid  (rd_valid)
);

// File: tb/i2c_txn_seq_tb_top.sv
module i2c_txn_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PLIM = 20;
    localparam int TICK = 3;
    localparam int LAT  = 2;
    localparam int NV   = 13;

    // {op, chip, alen, addr, len, fault index, fault kind (0 none,1 bad status,2 no flag), stop fail}
    localparam logic [56:0] VEC [NV] = '{
        {2'd0, 7'h50, 3'd2, 32'h0000_1234, 5'd3, 5'd31, 2'd0, 1'b0},
        {2'd0, 7'h22, 3'd0, 32'h0000_0000, 5'd1, 5'd31, 2'd0, 1'b0},
        {2'd1, 7'h50, 3'd2, 32'h0000_A1B2, 5'd3, 5'd31, 2'd0, 1'b0},
        {2'd1, 7'h3C, 3'd0, 32'h0000_0000, 5'd2, 5'd31, 2'd0, 1'b0},
        {2'd1, 7'h11, 3'd4, 32'h0102_0304, 5'd1, 5'd31, 2'd0, 1'b0},
        {2'd2, 7'h48, 3'd3, 32'h0000_0999, 5'd5, 5'd31, 2'd0, 1'b0},
        {2'd0, 7'h2A, 3'd1, 32'h0000_0077, 5'd2, 5'd1,  2'd1, 1'b0},
        {2'd1, 7'h2B, 3'd1, 32'h0000_0055, 5'd3, 5'd6,  2'd1, 1'b0},
        {2'd0, 7'h2C, 3'd0, 32'h0000_0000, 5'd2, 5'd2,  2'd2, 1'b0},
        {2'd0, 7'h2D, 3'd1, 32'h0000_0010, 5'd1, 5'd31, 2'd0, 1'b1},
        {2'd0, 7'h2E, 3'd1, 32'h0000_0010, 5'd1, 5'd2,  2'd1, 1'b1},
        {2'd2, 7'h2F, 3'd0, 32'h0000_0000, 5'd1, 5'd1,  2'd1, 1'b0},
        {2'd1, 7'h30, 3'd0, 32'h0000_0000, 5'd0, 5'd31, 2'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [6:0]  req_chip = '0;
    logic [2:0]  req_alen = '0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        busy, done, wr_pop, rd_valid, cmd_valid;
    logic [31:0] err_word;
    logic [7:0]  wr_data, rd_data, cmd_ctrl, cmd_data;
    logic        bus_flag;
    logic [7:0]  bus_status, bus_rx;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    // Expected command list, built by the bench
    logic [7:0] e_ctrl [32];
    logic [7:0] e_data [32];
    logic [7:0] e_code [32];
    int         en;
    int         f_idx;
    int         f_kind;
    bit         s_fail;

    // Responder state
    int         ci, cur, pend, rxn, wcnt, mism;
    bit         is_stop;
    logic [7:0] rxbuf [32];
    int         cmd_cyc [32];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign wr_data = 8'h30 + 8'(wcnt);

    i2c_txn_seq #(
        .LEN_W(8), .ADDR_BYTES(4), .POLL_LIMIT(PLIM), .TICK_CYCLES(TICK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_chip(req_chip), .req_alen(req_alen), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .done(done), .err_word(err_word),
        .wr_data(wr_data), .wr_pop(wr_pop), .rd_valid(rd_valid),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl),
        .cmd_data(cmd_data), .bus_flag(bus_flag), .bus_status(bus_status),
        .bus_rx(bus_rx)
    );

    // Byte-master model: answers each command after LAT cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_flag <= 1'b0; bus_status <= 8'hF8; bus_rx <= 8'h00;
            ci <= 0; cur <= 0; pend <= 0; rxn <= 0; wcnt <= 0; mism <= 0;
            is_stop <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                ci <= 0; rxn <= 0; wcnt <= 0;
            end
            if (wr_pop) wcnt <= wcnt + 1;
            if (rd_valid) begin
                rxbuf[rxn] <= rd_data;
                rxn <= rxn + 1;
            end
            if (cmd_valid) begin
                if (ci >= en || cmd_ctrl != e_ctrl[ci] || cmd_data != e_data[ci])
                    mism <= mism + 1;
                if (ci < 32) cmd_cyc[ci] <= cyc;
                cur <= ci; ci <= ci + 1;
                bus_flag <= 1'b0; bus_status <= 8'hAA;
                pend <= LAT; is_stop <= cmd_ctrl[4];
            end else if (pend != 0) begin
                pend <= pend - 1;
                if (pend == 1) begin
                    if (is_stop) begin
                        if (!s_fail) bus_status <= 8'hF8;
                    end else if (cur == f_idx && f_kind == 1) begin
                        bus_status <= 8'h20; bus_flag <= 1'b1;
                    end else if (cur == f_idx && f_kind == 2) begin
                        bus_flag <= 1'b0;
                    end else begin
                        bus_status <= e_code[cur]; bus_flag <= 1'b1;
                        bus_rx <= 8'hC0 + 8'(cur);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic add(input logic [7:0] c, input logic [7:0] dt, input logic [7:0] cd);
        e_ctrl[en] = c; e_data[en] = dt; e_code[en] = cd; en++;
    endtask

    // Builds the expected command list from the requirements
    task automatic build(input logic [1:0] op, input logic [6:0] chip, input int al,
                         input logic [31:0] ad, input int ln, input int fi, input int fk, input bit sf);
        int nrx;
        en = 0;
        add(8'h60, 8'h00, 8'h08);
        if (op == 2'd0 || (op == 2'd1 && al != 0)) begin
            add(8'h40, {chip, 1'b0}, 8'h18);
            for (int i = al - 1; i >= 0; i--) add(8'h40, ad[8*i +: 8], 8'h28);
        end
        if (op == 2'd0) begin
            for (int i = 0; i < ln; i++) add(8'h40, 8'h30 + 8'(i), 8'h28);
        end else begin
            if (op == 2'd1 && al != 0) add(8'h60, 8'h00, 8'h10);
            add(8'h40, {chip, 1'b1}, 8'h40);
            nrx = (op == 2'd2) ? 1 : ln;
            for (int i = 0; i < nrx; i++)
                add((i == nrx - 1) ? 8'h40 : 8'h44, 8'h00, (i == nrx - 1) ? 8'h58 : 8'h50);
        end
        f_idx = (fk != 0) ? fi : 99;
        f_kind = fk;
        s_fail = sf;
        if (fk != 0) en = fi + 1;
        add(8'h50, 8'h00, 8'hF8);
    endtask

    task automatic run_vec(input int v, input bit inject);
        logic [56:0] w;
        logic [31:0] exp_err, got_err;
        int m0, nexp, fstart, fend;
        logic [7:0] exp_rx [32];
        w = VEC[v];
        build(w[56:55], w[54:48], int'(w[47:45]), w[44:13], int'(w[12:8]),
              int'(w[7:3]), int'(w[2:1]), w[0]);
        // expected received bytes: receive commands answered correctly
        nexp = 0;
        fend = (f_kind != 0) ? f_idx : en - 1;
        for (int i = 0; i < fend; i++)
            if (e_code[i] == 8'h50 || e_code[i] == 8'h58) begin
                exp_rx[nexp] = 8'hC0 + 8'(i); nexp++;
            end
        if (f_kind == 1)
            exp_err = {8'h01, e_ctrl[f_idx] | 8'h08, 8'h20, e_code[f_idx]};
        else if (f_kind == 2)
            exp_err = {8'h02, e_ctrl[f_idx], 8'hAA, e_code[f_idx]};
        else if (s_fail)
            exp_err = {8'h02, 8'h50, 8'hAA, 8'hF8};
        else
            exp_err = 32'h0;
        m0 = mism;
        @(negedge clk);
        req_op = w[56:55]; req_chip = w[54:48]; req_alen = w[47:45];
        req_addr = w[44:13]; req_len = {3'b000, w[12:8]}; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (6) @(negedge clk);
            req_op = 2'd2; req_chip = 7'h7F; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        got_err = err_word;
        chk(got_err == exp_err, $sformatf("R6 R7 R8 R9 error word vec %0d", v), got_err, exp_err);
        chk(mism == m0, $sformatf("R1 R2 R3 R5 R10 command content vec %0d", v), 32'(mism - m0), 0);
        chk(ci == en, $sformatf("R1 R2 R5 R8 command count vec %0d", v), 32'(ci), 32'(en));
        chk(rxn == nexp, $sformatf("R4 received byte count vec %0d", v), 32'(rxn), 32'(nexp));
        for (int i = 0; i < nexp && i < rxn; i++)
            chk(rxbuf[i] == exp_rx[i], $sformatf("R4 received byte %0d vec %0d", i, v),
                {24'h0, rxbuf[i]}, {24'h0, exp_rx[i]});
        if (f_kind == 2) begin
            fstart = cmd_cyc[f_idx]; fend = cmd_cyc[f_idx + 1];
            chk(fend - fstart == PLIM * TICK + 2, $sformatf("R7 poll window vec %0d", v),
                32'(fend - fstart), 32'(PLIM * TICK + 2));
        end
        @(negedge clk);
        chk(!done && !busy, $sformatf("R9 done single cycle vec %0d", v), {30'h0, done, busy}, 0);
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        en = 0; f_idx = 99; f_kind = 0; s_fail = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !cmd_valid, "R11 reset outputs", {29'h0, busy, done, cmd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !cmd_valid, "R11 idle after reset", {30'h0, busy, cmd_valid}, 0);
        for (int v = 0; v < NV; v++) run_vec(v, 1'b0);
        // Directed: request while busy must not change the running write (R9)
        run_vec(0, 1'b1);
        // Directed: read with four address bytes again after a fault run (R3)
        run_vec(4, 1'b0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule